// File: doc/BRIEF.md
# Bus Width Conversion Access Sequencer

This block sits between a 32-bit request port on the processor side and an external memory port. Each address space on the external port is set to 8 or 16 bits wide. The sequencer turns each byte, word or longword request into the number of narrow memory accesses that the request needs. It holds every access for a fixed number of states. On a read it packs the narrow read data into a right-justified 32-bit result. On a write it slices the write data out, most significant part first.

All the accesses of one request form a single bus cycle, and that cycle cannot be broken. An external master may request the bus at any time. The grant is given only at the boundary between bus cycles. Instruction fetches are always widened to the aligned 32-bit pair that contains the addressed word.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable until that edge. `req_ready` is low while a bus cycle is running, while `breq` is high, and while `bgrant` is high. The result is a one-clock `done` pulse with `rdata`, and it has no back-pressure. The space used is selected by the upper `SPACE_W` address bits. `space_is16[s]` set to 1 makes space `s` 16 bits wide.

Top module: `bus_width_seq`

## Requirements
- R1: The number of memory accesses is 4 for a longword in an 8-bit space, 2 for a longword in a 16-bit space, 2 for a word in an 8-bit space, and 1 otherwise. Each access keeps `mem_rd` or `mem_wr` high for `STATES` clocks (default 2), so a longword in an 8-bit space strobes for 8 clocks in a row.
- R2: The accesses go to ascending addresses starting at the aligned base. The first access carries the most significant byte or halfword (big-endian). On an 8-bit space the data uses `mem_rdata[7:0]` and `mem_wdata[7:0]`.
- R3: `req_size` encodes 00 as byte, 01 as word, and 10 or 11 as longword. The read result is right-justified: a byte is in `rdata[7:0]` and a word is in `rdata[15:0]`, with the unused upper bits zero.
- R4: A byte access to a 16-bit space is a single access with `mem_byte` high. An even address uses lane `[15:8]` and an odd address uses lane `[7:0]`. A write drives the byte on both lanes.
- R5: A write sends the write data most significant part first, and `mem_rd` and `mem_wr` are never high together.
- R6: A fetch (`req_fetch`=1) is always a longword read with address bits [1:0] forced to zero, whatever `req_size` and `req_write` say. It returns the aligned 32-bit pair.
- R7: A word request ignores address bit 0 and a longword request ignores bits [1:0].
- R8: `bgrant` never rises inside a bus cycle. A `breq` raised during a cycle is held pending, and `bgrant` is high from the clock after the final access state, which is the clock of `done`.
- R9: While `breq` or `bgrant` is high, `req_ready` is low. While `bgrant` is high, no memory strobe is active.
- R10: `done` is high for exactly one clock, the clock after the final access state, and `rdata` is valid in that clock. `req_ready` is high again in that clock if no bus request is present.
- R11: After reset, `req_ready` is 1 and `done`, `bgrant`, `mem_rd` and `mem_wr` are 0.
- R12: `bgrant` falls one clock after `breq` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| space_is16 | input | NUM_SPACES | Per-space width select (1 = 16-bit) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address; upper SPACE_W bits select the space |
| req_size | input | 2 | 00 byte, 01 word, 1x longword |
| req_write | input | 1 | 1 = write |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_wdata | input | 32 | Right-justified write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Right-justified read result, valid with done |
| mem_addr | output | ADDR_W | Memory byte address of current access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wide | output | 1 | Current access is on a 16-bit space |
| mem_byte | output | 1 | Single byte access on a 16-bit space |
| mem_wdata | output | 16 | Write data of the current access |
| mem_rdata | input | 16 | Read data, sampled in the last state of each access |
| breq | input | 1 | External bus request |
| bgrant | output | 1 | Registered bus grant |

## Verification
A wrong beat counter or state counter shows up within one bus cycle. The strobe length is then different from `STATES` times the expected number of accesses, or `done` arrives early or late. A wrong shift in the pack or slice registers changes `rdata` or the memory contents by the end of the same request. A grant decision taken at the wrong time raises `bgrant` while a strobe is still high, and this is visible in the very clock it happens.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LALT = 2'b11
  } size_e;

  typedef struct packed {
    logic       wr;
    logic       wide;
    logic       lone;
    logic [2:0] beats;
    logic [2:0] nbytes;
  } shape_t;
endpackage

// File: rtl/bws_plan.sv
module bws_plan
  import bws_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SPACE_W = 2,
  localparam int NUM_SPACES = 1 << SPACE_W
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  input  logic                  write,
  input  logic                  fetch,
  input  logic [NUM_SPACES-1:0] space_is16,
  output logic [ADDR_W-1:0]     base,
  output shape_t                shape
);
  size_e eff;
  logic [SPACE_W-1:0] space;
  logic wide;

  always_comb begin
    space = addr[ADDR_W-1 -: SPACE_W];
    wide  = space_is16[space];
    if (fetch) eff = SZ_LONG;
    else       eff = size_e'(size);
    base = addr;
    shape.wr   = write & ~fetch;
    shape.wide = wide;
    shape.lone = 1'b0;
    unique case (eff)
      SZ_BYTE: begin
        shape.nbytes = 3'd1;
        shape.beats  = 3'd1;
        shape.lone   = wide;
      end
      SZ_WORD: begin
        base[0]      = 1'b0;
        shape.nbytes = 3'd2;
        shape.beats  = wide ? 3'd1 : 3'd2;
      end
      default: begin
        base[1:0]    = 2'b00;
        shape.nbytes = 3'd4;
        shape.beats  = wide ? 3'd2 : 3'd4;
      end
    endcase
  end
endmodule

// File: rtl/bws_beat_timer.sv
module bws_beat_timer #(
  parameter int STATES = 2,
  parameter int BEAT_W = 3,
  localparam int CNT_W = (STATES > 1) ? $clog2(STATES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] beats_in,
  output logic              busy,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              beat_end,
  output logic              cycle_end,
  output logic              done
);
  logic [CNT_W-1:0]  st_q;
  logic [BEAT_W-1:0] last_q;

  assign beat_end  = busy && (st_q == CNT_W'(STATES - 1));
  assign cycle_end = beat_end && (beat_idx == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      st_q     <= '0;
      beat_idx <= '0;
      last_q   <= '0;
      done     <= 1'b0;
    end else begin
      done <= cycle_end;
      if (start) begin
        busy     <= 1'b1;
        st_q     <= '0;
        beat_idx <= '0;
        last_q   <= beats_in - BEAT_W'(1);
      end else if (busy) begin
        if (beat_end) begin
          st_q <= '0;
          if (cycle_end) busy <= 1'b0;
          else           beat_idx <= beat_idx + BEAT_W'(1);
        end else begin
          st_q <= st_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bws_datapath.sv
module bws_datapath (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  nbytes,
  input  logic [31:0] wdata_in,
  input  logic        wide,
  input  logic        lone,
  input  logic        addr0,
  input  logic        beat_end,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_wdata,
  output logic [31:0] rdata
);
  logic [31:0] wsh;
  logic [31:0] wjust;

  always_comb begin
    unique case (nbytes)
      3'd1:    wjust = wdata_in << 24;
      3'd2:    wjust = wdata_in << 16;
      default: wjust = wdata_in;
    endcase
  end

  always_comb begin
    if (wide && !lone) mem_wdata = wsh[31:16];
    else if (wide)     mem_wdata = {wsh[31:24], wsh[31:24]};
    else               mem_wdata = {8'h00, wsh[31:24]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsh   <= '0;
      rdata <= '0;
    end else if (start) begin
      wsh   <= wjust;
      rdata <= '0;
    end else if (beat_end) begin
      if (wide && !lone) begin
        rdata <= {rdata[15:0], mem_rdata};
        wsh   <= wsh << 16;
      end else if (wide) begin
        rdata <= {rdata[23:0], addr0 ? mem_rdata[7:0] : mem_rdata[15:8]};
      end else begin
        rdata <= {rdata[23:0], mem_rdata[7:0]};
        wsh   <= wsh << 8;
      end
    end
  end
endmodule

// File: rtl/bws_arbiter.sv
module bws_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic breq,
  input  logic busy,
  input  logic cycle_end,
  output logic bgrant
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bgrant <= 1'b0;
    else        bgrant <= breq && (!busy || cycle_end);
  end
endmodule

// File: rtl/bus_width_seq.sv
module bus_width_seq
  import bws_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SPACE_W = 2,
  parameter int STATES  = 2,
  localparam int NUM_SPACES = 1 << SPACE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SPACES-1:0] space_is16,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic                  req_write,
  input  logic                  req_fetch,
  input  logic [31:0]           req_wdata,
  output logic                  done,
  output logic [31:0]           rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  mem_wide,
  output logic                  mem_byte,
  output logic [15:0]           mem_wdata,
  input  logic [15:0]           mem_rdata,
  input  logic                  breq,
  output logic                  bgrant
);
  logic [ADDR_W-1:0] base_c, base_q, offs;
  shape_t shape_c, shape_q;
  logic start, busy, beat_end, cycle_end;
  logic [2:0] beat_idx;

  bws_plan #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) u_plan (
    .addr(req_addr), .size(req_size), .write(req_write), .fetch(req_fetch),
    .space_is16(space_is16), .base(base_c), .shape(shape_c)
  );

  assign req_ready = !busy && !breq && !bgrant;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      shape_q <= '0;
    end else if (start) begin
      base_q  <= base_c;
      shape_q <= shape_c;
    end
  end

  bws_beat_timer #(.STATES(STATES), .BEAT_W(3)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .beats_in(shape_c.beats),
    .busy(busy), .beat_idx(beat_idx), .beat_end(beat_end),
    .cycle_end(cycle_end), .done(done)
  );

  bws_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .start(start), .nbytes(shape_c.nbytes),
    .wdata_in(req_wdata), .wide(shape_q.wide), .lone(shape_q.lone),
    .addr0(base_q[0]), .beat_end(beat_end), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .rdata(rdata)
  );

  bws_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .breq(breq), .busy(busy),
    .cycle_end(cycle_end), .bgrant(bgrant)
  );

  always_comb begin
    offs = '0;
    offs[3:0] = shape_q.wide ? {beat_idx, 1'b0} : {1'b0, beat_idx};
  end

  assign mem_addr = base_q + offs;
  assign mem_rd   = busy && !shape_q.wr;
  assign mem_wr   = busy && shape_q.wr;
  assign mem_wide = busy && shape_q.wide;
  assign mem_byte = busy && shape_q.lone;
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_fetch,
  input logic              breq,
  input logic              bgrant,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done
);
  // R9
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bgrant |-> !(mem_rd || mem_wr));
  // R9
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (breq || bgrant) |-> !req_ready);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_fetch) |=> (mem_addr[1:0] == 2'b00 && mem_rd));
  // R5
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R8
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bgrant) |-> $past(breq));
  // R12
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bgrant && !breq) |=> !bgrant);
endmodule

bind bus_width_seq bws_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_fetch(req_fetch), .breq(breq), .bgrant(bgrant), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .done(done)
);

// File: tb/bus_width_seq_tb.sv
module bus_width_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0] space_is16 = 2'b10;
  logic req_valid = 0, req_write = 0, req_fetch = 0, breq = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'b00;
  logic [31:0] req_wdata = '0;
  logic req_ready, done, mem_rd, mem_wr, mem_wide, mem_byte, bgrant;
  logic [31:0] rdata;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0] m [0:511];
  int checks = 0, fails = 0, cyc = 0;

  bus_width_seq #(.ADDR_W(AW), .SPACE_W(1), .STATES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .space_is16(space_is16), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_fetch(req_fetch), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wide(mem_wide), .mem_byte(mem_byte),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .breq(breq), .bgrant(bgrant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ix(logic [AW-1:0] a);
    return {23'd0, a[15], a[7:0]};
  endfunction

  always_comb begin
    if (mem_addr[15]) mem_rdata = {m[ix({mem_addr[15:1], 1'b0})], m[ix({mem_addr[15:1], 1'b1})]};
    else              mem_rdata = {8'h00, m[ix(mem_addr)]};
  end

  always @(negedge clk) begin
    if (mem_wr) begin
      if (!mem_addr[15])  m[ix(mem_addr)] = mem_wdata[7:0];
      else if (mem_byte)  m[ix(mem_addr)] = mem_addr[0] ? mem_wdata[7:0] : mem_wdata[15:8];
      else begin
        m[ix({mem_addr[15:1], 1'b0})] = mem_wdata[15:8];
        m[ix({mem_addr[15:1], 1'b1})] = mem_wdata[7:0];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd4(logic [AW-1:0] a);
    return {m[ix(a)], m[ix(a + 1)], m[ix(a + 2)], m[ix(a + 3)]};
  endfunction

  int strobes, gr_busy, breq_at;
  logic [AW-1:0] first_a, last_a;
  logic [31:0] got;
  logic gr_done, rdy_done;

  task automatic xfer(logic [AW-1:0] a, logic [1:0] sz, logic wr, logic fe, logic [31:0] wd);
    int k;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_write = wr; req_fetch = fe; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    strobes = 0; gr_busy = 0; k = 0; first_a = mem_addr;
    while (!done && k < 100) begin
      k++;
      if (k == breq_at) breq = 1;
      if (mem_rd || mem_wr) begin strobes++; last_a = mem_addr; end
      if (bgrant) gr_busy++;
      @(negedge clk);
    end
    got = rdata; gr_done = bgrant; rdy_done = req_ready;
    @(negedge clk);
    chk("R10 done single", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 ready", {31'd0, req_ready}, 1);
    chk("R11 done", {31'd0, done}, 0);
    chk("R11 grant", {31'd0, bgrant}, 0);
    chk("R11 strobes", {30'd0, mem_rd, mem_wr}, 0);
  endtask

  task automatic t_reads;
    xfer(16'h0010, 2'b10, 0, 0, 0);
    chk("R1 long8 strobes", strobes, 8);
    chk("R2 long8 first", first_a, 16'h0010);
    chk("R2 long8 last", last_a, 16'h0013);
    chk("R2 long8 data", got, rd4(16'h0010));
    chk("R10 ready at done", {31'd0, rdy_done}, 1);
    xfer(16'h8020, 2'b11, 0, 0, 0);
    chk("R1 long16 strobes", strobes, 4);
    chk("R2 long16 data", got, rd4(16'h8020));
    xfer(16'h0006, 2'b01, 0, 0, 0);
    chk("R1 word8 strobes", strobes, 4);
    chk("R3 word8 data", got, {16'h0, m[ix(16'h0006)], m[ix(16'h0007)]});
    xfer(16'h8005, 2'b00, 0, 0, 0);
    chk("R4 byte16 odd strobes", strobes, 2);
    chk("R4 byte16 odd data", got, {24'h0, m[ix(16'h8005)]});
    xfer(16'h8004, 2'b00, 0, 0, 0);
    chk("R4 byte16 even data", got, {24'h0, m[ix(16'h8004)]});
    xfer(16'h0021, 2'b00, 0, 0, 0);
    chk("R3 byte8 data", got, {24'h0, m[ix(16'h0021)]});
    chk("R1 byte8 strobes", strobes, 2);
  endtask

  task automatic t_align;
    xfer(16'h0009, 2'b01, 0, 0, 0);
    chk("R7 word misalign first", first_a, 16'h0008);
    chk("R7 word misalign data", got, {16'h0, m[ix(16'h0008)], m[ix(16'h0009)]});
    xfer(16'h8033, 2'b10, 0, 0, 0);
    chk("R7 long misalign data", got, rd4(16'h8030));
  endtask

  task automatic t_fetch;
    xfer(16'h0016, 2'b01, 0, 1, 0);
    chk("R6 fetch8 first", first_a, 16'h0014);
    chk("R6 fetch8 strobes", strobes, 8);
    chk("R6 fetch8 data", got, rd4(16'h0014));
    xfer(16'h8042, 2'b00, 1, 1, 32'hDEADBEEF);
    chk("R6 fetch16 data", got, rd4(16'h8040));
    chk("R6 fetch no write", {24'h0, m[ix(16'h8040)]}, {24'h0, 8'(16'h140 * 37 + 11)});
  endtask

  task automatic t_writes;
    xfer(16'h0040, 2'b10, 1, 0, 32'hA1B2C3D4);
    chk("R5 long8 write", rd4(16'h0040), 32'hA1B2C3D4);
    chk("R5 long8 write first", first_a, 16'h0040);
    chk("R1 long8 write strobes", strobes, 8);
    xfer(16'h8050, 2'b10, 1, 0, 32'h11223344);
    chk("R5 long16 write", rd4(16'h8050), 32'h11223344);
    xfer(16'h0060, 2'b01, 1, 0, 32'hFFFF5A6B);
    chk("R5 word8 write", {16'h0, m[ix(16'h0060)], m[ix(16'h0061)]}, 32'h5A6B);
    chk("R5 word8 neighbour", {24'h0, m[ix(16'h0062)]}, {24'h0, 8'(16'h062 * 37 + 11)});
    xfer(16'h8071, 2'b00, 1, 0, 32'h000000C7);
    chk("R4 byte16 write odd", {24'h0, m[ix(16'h8071)]}, 32'hC7);
    chk("R4 byte16 write other lane", {24'h0, m[ix(16'h8070)]}, {24'h0, 8'(16'h170 * 37 + 11)});
  endtask

  task automatic t_busreq;
    breq_at = 3;
    xfer(16'h0010, 2'b10, 0, 0, 0);
    breq_at = 0;
    chk("R8 no grant inside cycle", gr_busy, 0);
    chk("R8 grant at done", {31'd0, gr_done}, 1);
    chk("R9 ready low while granted", {31'd0, req_ready}, 0);
    chk("R8 data with pending req", got, rd4(16'h0010));
    breq = 0;
    @(negedge clk);
    chk("R12 grant drops", {31'd0, bgrant}, 0);
    breq = 1;
    req_valid = 1; req_addr = 16'h0000; req_size = 2'b00; req_write = 0; req_fetch = 0;
    @(negedge clk);
    chk("R9 ready low on breq", {31'd0, req_ready}, 0);
    chk("R9 no strobe while granted", {30'd0, mem_rd, mem_wr}, 0);
    chk("R8 idle grant", {31'd0, bgrant}, 1);
    req_valid = 0; breq = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 ready back", {31'd0, req_ready}, 1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) m[i] = 8'(i * 37 + 11);
    breq_at = 0;
    #(CLK_PERIOD * 2 + 1);
    t_reset;
    @(negedge clk);
    rst_n = 1;
    t_reset;
    t_reads;
    t_align;
    t_fetch;
    t_writes;
    t_busreq;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule